// File: doc/BRIEF.md
# Packed Single-Precision Vector Divider

This unit divides two 256-bit vectors lane by lane. Each vector holds eight IEEE-754 binary32 numbers. Lane k of the quotient is lane k of the first source divided by lane k of the second. A two-bit form select sets how many lanes are computed and what the upper half of the result holds. In the preserving 128-bit form, only the low four lanes are divided and the upper half is copied from a destination-old input. In the clearing 128-bit form, only the low four lanes are divided and the upper half is zero. In the full form, all eight lanes are divided.

There is only one iterative restoring mantissa divider, and the lanes take turns using it. Each lane spends one load cycle, 26 quotient-bit cycles and one writeback cycle in the core. The quotient is rounded to nearest-even, and the unit produces gradual-underflow results. It collects six exception flags, ORed over the lanes that were actually computed. Operands enter through a valid/ready handshake, and the result leaves through a second one.

Top module: `fp32div_packed`

## Requirements
- R1: Each active lane k (bits [32k+31:32k]) holds src1 lane k divided by src2 lane k, rounded to nearest-even.
- R2: Form 0 (preserving 128-bit) computes lanes 0..3, and result bits 255:128 equal dst_old bits 255:128 captured at acceptance.
- R3: Form 1 (clearing 128-bit) computes lanes 0..3 and drives result bits 255:128 to zero.
- R4: Forms 2 and 3 (full width) compute all eight lanes.
- R5: The flags are bit 0 invalid, bit 1 denormal operand, bit 2 divide-by-zero, bit 3 overflow, bit 4 underflow and bit 5 inexact. They are cleared at each acceptance and ORed over computed lanes only, so lanes that are not computed have no effect.
- R6: A nonzero finite value divided by zero gives an infinity whose sign is the XOR of the operand signs, and sets divide-by-zero. An infinite dividend gives an infinity with no flag.
- R7: 0/0, inf/inf, or any signaling NaN operand gives 0xFFC00000 and sets invalid.
- R8: With no signaling NaN present, a quiet NaN in src1 is returned first. Otherwise a quiet NaN in src2 is returned.
- R9: A rounded result too large for binary32 gives a signed infinity and sets overflow and inexact.
- R10: A result below the normal range is returned as a correctly rounded subnormal. Underflow is set only when that result is inexact.
- R11: A subnormal operand is normalised before division and sets the denormal flag.
- R12: in_ready is high only when the unit is idle and out of reset. out_valid is low in reset. result and flags stay stable with out_valid high until out_ready is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and form are presented |
| in_ready | output | 1 | Unit idle, operation accepted when in_valid is high |
| mode | input | 2 | Form select: 0 preserving 128, 1 clearing 128, 2/3 full 256 |
| src1 | input | 256 | Dividend lanes |
| src2 | input | 256 | Divisor lanes |
| dst_old | input | 256 | Previous destination value, used for the upper half in form 0 |
| out_valid | output | 1 | Result and flags are valid |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 256 | Quotient lanes |
| flags | output | 6 | Accumulated exception flags |

## Verification
The assertions take two things as given. First, the consumer may hold out_ready low for any number of cycles. Second, dst_old is only meaningful at the acceptance handshake, which is why the checker captures it there rather than comparing against the live input. They also assume form values 2 and 3 never need an upper-half rule of their own. The stimulus presents operands only when in_ready is seen high and drops in_valid one cycle later. It changes dst_old only between operations, and it holds out_ready low for several cycles before every handshake so that the hold rule is actually exercised.

// File: rtl/fp32div_pkg.sv
package fp32div_pkg;

  localparam int FP_W   = 32;
  localparam int MAN_W  = 24;
  localparam int QUO_W  = MAN_W + 2;
  localparam int NFLAG  = 6;

  localparam int FL_INV = 0;
  localparam int FL_DEN = 1;
  localparam int FL_DZ  = 2;
  localparam int FL_OVF = 3;
  localparam int FL_UNF = 4;
  localparam int FL_PRE = 5;

  localparam logic [FP_W-1:0] QNAN_DEFAULT = 32'hFFC0_0000;

  typedef enum logic [1:0] {
    FORM_KEEP128 = 2'd0,
    FORM_ZERO128 = 2'd1,
    FORM_FULL    = 2'd2,
    FORM_FULL_B  = 2'd3
  } form_e;

  typedef struct packed {
    logic [MAN_W-1:0]  man;
    logic signed [11:0] exp;
  } norm_t;

  // Leading one of the significand moved to bit 23; subnormals get an
  // exponent below 1 so the quotient exponent stays exact.
  function automatic norm_t normalize(input logic [FP_W-1:0] x);
    norm_t n;
    int    pos;
    pos   = 0;
    n.man = {1'b1, x[22:0]};
    n.exp = $signed({4'd0, x[30:23]});
    if (x[30:23] == 8'd0 && x[22:0] != 23'd0) begin
      for (int i = 0; i < 23; i++) begin
        if (x[i]) pos = i;
      end
      n.man = 24'({1'b0, x[22:0]} << (23 - pos));
      n.exp = 12'(pos - 22);
    end
    return n;
  endfunction

endpackage

// File: rtl/fp32div_iter_core.sv
module fp32div_iter_core #(
  parameter int MW = 24,
  parameter int QW = MW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [MW-1:0] dvd,
  input  logic [MW-1:0] dvs,
  output logic [QW-1:0] quo,
  output logic          rem_nz
);

  logic [MW:0]   r_q, r_d;
  logic [QW-1:0] q_q, q_d;
  logic [MW-1:0] d_q, d_d;
  logic [MW:0]   diff;
  logic          ge;

  always_comb begin
    ge   = r_q >= {1'b0, d_q};
    diff = ge ? (r_q - {1'b0, d_q}) : r_q;
    r_d  = r_q;
    q_d  = q_q;
    d_d  = d_q;
    if (load) begin
      r_d = {1'b0, dvd};
      q_d = '0;
      d_d = dvs;
    end else if (step) begin
      r_d = {diff[MW-1:0], 1'b0};
      q_d = {q_q[QW-2:0], ge};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q <= '0;
      q_q <= '0;
      d_q <= '0;
    end else if (load || step) begin
      r_q <= r_d;
      q_q <= q_d;
      d_q <= d_d;
    end
  end

  assign quo    = q_q;
  assign rem_nz = |r_q;

endmodule

// File: rtl/fp32div_lane_fn.sv
module fp32div_lane_fn
  import fp32div_pkg::*;
(
  input  logic [FP_W-1:0]  op_a,
  input  logic [FP_W-1:0]  op_b,
  input  logic [QUO_W-1:0] quo,
  input  logic             rem_nz,
  output logic [MAN_W-1:0] man_a,
  output logic [MAN_W-1:0] man_b,
  output logic [FP_W-1:0]  q_out,
  output logic [NFLAG-1:0] q_flg
);

  norm_t na, nb;
  assign na    = normalize(op_a);
  assign nb    = normalize(op_b);
  assign man_a = na.man;
  assign man_b = nb.man;

  logic a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_zero, b_zero, a_den, b_den;
  assign a_nan  = (&op_a[30:23]) && (|op_a[22:0]);
  assign b_nan  = (&op_b[30:23]) && (|op_b[22:0]);
  assign a_snan = a_nan && !op_a[22];
  assign b_snan = b_nan && !op_b[22];
  assign a_inf  = (&op_a[30:23]) && !(|op_a[22:0]);
  assign b_inf  = (&op_b[30:23]) && !(|op_b[22:0]);
  assign a_zero = (op_a[30:0] == 31'd0);
  assign b_zero = (op_b[30:0] == 31'd0);
  assign a_den  = (op_a[30:23] == 8'd0) && (|op_a[22:0]);
  assign b_den  = (op_b[30:23] == 8'd0) && (|op_b[22:0]);

  logic signed [11:0] e, shf;
  logic [QUO_W-1:0]   v, v2;
  logic [4:0]         sh;
  logic [7:0]         ef;
  logic [30:0]        rnd;
  logic               sgn, tiny, lost, inc, inexact, ovf;

  always_comb begin
    sgn  = op_a[31] ^ op_b[31];
    e    = na.exp - nb.exp + 12'sd127 - (quo[QUO_W-1] ? 12'sd0 : 12'sd1);
    v    = quo[QUO_W-1] ? {quo[25:2], quo[1], quo[0] | rem_nz}
                        : {quo[24:1], quo[0], rem_nz};
    tiny = e < 12'sd1;
    shf  = 12'sd1 - e;
    sh   = !tiny ? 5'd0 : ((shf > 12'sd26) ? 5'd26 : 5'(shf));
    lost = |(v & ((26'd1 << sh) - 26'd1));
    v2   = (v >> sh) | {25'd0, lost};
    inexact = v2[1] | v2[0];
    inc  = v2[1] & (v2[0] | v2[2]);
    ef   = v2[25] ? e[7:0] : 8'd0;
    rnd  = {ef, v2[24:2]} + {30'd0, inc};
    ovf  = (e > 12'sd254) || (rnd[30:23] == 8'hFF);

    q_out = '0;
    q_flg = '0;
    if (a_snan || b_snan) begin
      q_out = QNAN_DEFAULT;
      q_flg[FL_INV] = 1'b1;
    end else if (a_nan) begin
      q_out = op_a;
    end else if (b_nan) begin
      q_out = op_b;
    end else if ((a_zero && b_zero) || (a_inf && b_inf)) begin
      q_out = QNAN_DEFAULT;
      q_flg[FL_INV] = 1'b1;
    end else begin
      q_flg[FL_DEN] = a_den | b_den;
      if (a_inf || b_zero) begin
        q_out = {sgn, 8'hFF, 23'd0};
        q_flg[FL_DZ] = b_zero && !a_inf;
      end else if (a_zero || b_inf) begin
        q_out = {sgn, 31'd0};
      end else if (ovf) begin
        q_out = {sgn, 8'hFF, 23'd0};
        q_flg[FL_OVF] = 1'b1;
        q_flg[FL_PRE] = 1'b1;
      end else begin
        q_out = {sgn, rnd};
        q_flg[FL_PRE] = inexact;
        q_flg[FL_UNF] = tiny && inexact;
      end
    end
  end

endmodule

// File: rtl/fp32div_packed.sv
module fp32div_packed
  import fp32div_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          mode,
  input  logic [LANES*LW-1:0] src1,
  input  logic [LANES*LW-1:0] src2,
  input  logic [LANES*LW-1:0] dst_old,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*LW-1:0] result,
  output logic [NFLAG-1:0]    flags
);

  localparam int VW   = LANES * LW;
  localparam int LIDX = $clog2(LANES);
  localparam int CW   = $clog2(QUO_W);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_ITER, S_WRITE, S_DONE} st_e;

  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  st_e              st_q, st_d;
  logic [LIDX-1:0]  lane_q, lane_d, last_q, last_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [VW-1:0]    a_q, b_q, res_q, res_d;
  logic [NFLAG-1:0] flg_q, flg_d;
  logic             cap_en, wr_en;

  logic [LW-1:0]    a_cur, b_cur, lane_res;
  logic [NFLAG-1:0] lane_flg;
  logic [MAN_W-1:0] man_a, man_b;
  logic [QUO_W-1:0] quo;
  logic             rem_nz;

  assign a_cur = a_q[lane_q*LW +: LW];
  assign b_cur = b_q[lane_q*LW +: LW];

  fp32div_lane_fn u_lane (
    .op_a(a_cur), .op_b(b_cur), .quo(quo), .rem_nz(rem_nz),
    .man_a(man_a), .man_b(man_b), .q_out(lane_res), .q_flg(lane_flg)
  );

  fp32div_iter_core #(.MW(MAN_W), .QW(QUO_W)) u_core (
    .clk(clk), .rst_n(rst_i_n),
    .load(st_q == S_LOAD), .step(st_q == S_ITER),
    .dvd(man_a), .dvs(man_b), .quo(quo), .rem_nz(rem_nz)
  );

  assign cap_en = (st_q == S_IDLE) && in_valid;
  assign wr_en  = (st_q == S_WRITE);

  always_comb begin
    st_d   = st_q;
    lane_d = lane_q;
    last_d = last_q;
    cnt_d  = cnt_q;
    res_d  = res_q;
    flg_d  = flg_q;
    unique case (st_q)
      S_IDLE: if (in_valid) begin
        st_d   = S_LOAD;
        lane_d = '0;
        last_d = mode[1] ? LIDX'(LANES - 1) : LIDX'(LANES / 2 - 1);
        res_d  = (form_e'(mode) == FORM_KEEP128) ? dst_old : '0;
        flg_d  = '0;
      end
      S_LOAD: begin
        st_d  = S_ITER;
        cnt_d = '0;
      end
      S_ITER: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(QUO_W - 1)) st_d = S_WRITE;
      end
      S_WRITE: begin
        res_d[lane_q*LW +: LW] = lane_res;
        flg_d = flg_q | lane_flg;
        if (lane_q == last_q) begin
          st_d = S_DONE;
        end else begin
          lane_d = lane_q + 1'b1;
          st_d   = S_LOAD;
        end
      end
      S_DONE: if (out_ready) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= S_IDLE;
      lane_q <= '0;
      last_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      lane_q <= lane_d;
      last_q <= last_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (cap_en) begin
      a_q <= src1;
      b_q <= src2;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (cap_en || wr_en) begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign in_ready  = (st_q == S_IDLE) && rst_i_n;
  assign out_valid = (st_q == S_DONE);
  assign result    = res_q;
  assign flags     = flg_q;

endmodule

// File: rtl/fp32div_chk.sv
module fp32div_chk #(
  parameter int VW = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [1:0]      mode,
  input logic [VW/2-1:0] dst_up,
  input logic            out_valid,
  input logic            out_ready,
  input logic [VW-1:0]   result,
  input logic [5:0]      flags
);

  logic [1:0]      md_q;
  logic [VW/2-1:0] up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md_q <= 2'd2;
      up_q <= '0;
    end else if (in_valid && in_ready) begin
      md_q <= mode;
      up_q <= dst_up;
    end
  end

  // R12
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(flags));

  // R12
  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R3
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && md_q == 2'd1 |-> result[VW-1:VW/2] == '0);

  // R2
  p_upper_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && md_q == 2'd0 |-> result[VW-1:VW/2] == up_q);

  // R9
  p_ovf_inexact_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags[3] |-> flags[5]);

  // R10
  p_unf_inexact_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags[4] |-> flags[5]);

endmodule

bind fp32div_packed fp32div_chk #(.VW(LANES * LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mode(mode), .dst_up(dst_old[LANES*LW-1:LANES*LW/2]),
  .out_valid(out_valid), .out_ready(out_ready), .result(result), .flags(flags)
);

// File: tb/test_fp32div_packed.sv
`timescale 1ns/1ps
module test_fp32div_packed;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, out_valid, out_ready;
  logic [1:0]   mode;
  logic [255:0] src1, src2, dst_old, result;
  logic [5:0]   flags;

  always #10 clk = ~clk;

  fp32div_packed i_fp32div_packed (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mode(mode), .src1(src1), .src2(src2), .dst_old(dst_old),
    .out_valid(out_valid), .out_ready(out_ready), .result(result), .flags(flags)
  );

  typedef struct {
    logic [255:0] res;
    logic [5:0]   flg;
    logic [1:0]   md;
    string        tg;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   errors = 0;
  int   done_ops = 0;

  task automatic chk(input logic ok, input string req, input logic [255:0] act,
                     input logic [255:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(input logic [1:0] md, input logic [31:0] a [8],
                      input logic [31:0] b [8], input logic [255:0] dold,
                      input logic [31:0] r [8], input logic [5:0] f, input string tg);
    exp_t e;
    for (int i = 0; i < 8; i++) e.res[i*32 +: 32] = r[i];
    if (md == 2'd0) e.res[255:128] = dold[255:128];
    if (md == 2'd1) e.res[255:128] = '0;
    e.flg = f;
    e.md  = md;
    e.tg  = tg;
    sb.push_back(e);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      src1[i*32 +: 32] = a[i];
      src2[i*32 +: 32] = b[i];
    end
    dst_old  = dold;
    mode     = md;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    logic [255:0] snap;
    logic [5:0]   fsnap;
    exp_t         e;
    string        up;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (out_valid && sb.size() > 0) begin
        e     = sb.pop_front();
        snap  = result;
        fsnap = flags;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(out_valid && !in_ready && result == snap && flags == fsnap,
              "R12 hold", result, snap);
        end
        for (int i = 0; i < 8; i++) begin
          up = (i < 4) ? e.tg : ((e.md == 2'd0) ? "R2" : (e.md == 2'd1) ? "R3" : "R4");
          chk(result[i*32 +: 32] == e.res[i*32 +: 32], $sformatf("%s lane %0d", up, i),
              256'(result[i*32 +: 32]), 256'(e.res[i*32 +: 32]));
        end
        chk(flags == e.flg, "R5 flags", 256'(flags), 256'(e.flg));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(!out_valid && in_ready, "R12 release", 256'({out_valid, in_ready}), 256'(2'b01));
        done_ops++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R12: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] a [8];
    logic [31:0] b [8];
    logic [31:0] r [8];
    logic [255:0] d;
    rst_n = 1'b0; in_valid = 1'b0; mode = 2'd0;
    src1 = '0; src2 = '0; dst_old = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !in_ready, "R12 reset", 256'({out_valid, in_ready}), 256'(0));
    chk(flags == 6'd0, "R5 reset flags", 256'(flags), 256'(0));
    rst_n = 1'b1;

    // Full width: normal quotients, divide by zero, infinities, zeros (R1 R4 R6 R10)
    a = '{32'h40C00000, 32'h3F800000, 32'hBFC00000, 32'h3F800000,
          32'h7F800000, 32'h40000000, 32'h80000000, 32'h00800000};
    b = '{32'h40000000, 32'h40400000, 32'h3F000000, 32'h00000000,
          32'h40000000, 32'h7F800000, 32'h40000000, 32'h40000000};
    r = '{32'h40400000, 32'h3EAAAAAB, 32'hC0400000, 32'h7F800000,
          32'h7F800000, 32'h00000000, 32'h80000000, 32'h00400000};
    send(2'd2, a, b, '0, r, 6'b100100, "R1/R6");

    // Preserving 128: upper lanes hold a signaling NaN and 0/0 that must not flag (R2 R5)
    a = '{32'h3F800000, 32'h40000000, 32'hC0C00000, 32'h3F800000,
          32'h7F800001, 32'h00000000, 32'h7F800000, 32'h3F800000};
    b = '{32'h40000000, 32'h40400000, 32'h40400000, 32'hBF800000,
          32'h3F800000, 32'h00000000, 32'h7F800000, 32'h00000001};
    r = '{32'h3F000000, 32'h3F2AAAAB, 32'hC0000000, 32'hBF800000,
          32'h0, 32'h0, 32'h0, 32'h0};
    for (int i = 0; i < 8; i++) d[i*32 +: 32] = a[i];
    send(2'd0, a, b, d, r, 6'b100000, "R1");

    // Clearing 128: subnormal operand, overflow; upper lanes divide by zero, ignored (R3 R9 R11)
    a = '{32'h40C00000, 32'h00000001, 32'h7F000000, 32'h3F800000,
          32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000};
    b = '{32'h40000000, 32'h3F000000, 32'h3E800000, 32'h40400000,
          32'h0, 32'h0, 32'h0, 32'h0};
    r = '{32'h40400000, 32'h00000002, 32'h7F800000, 32'h3EAAAAAB,
          32'h0, 32'h0, 32'h0, 32'h0};
    send(2'd1, a, b, {8{32'hA5A5A5A5}}, r, 6'b101010, "R9/R11");

    // Full width specials (R7 R8 R9 R10 R11)
    a = '{32'h00000000, 32'h7F800000, 32'h7F800001, 32'h7FC00001,
          32'h3F800000, 32'h7F000000, 32'h00800000, 32'h00000001};
    b = '{32'h00000000, 32'hFF800000, 32'h3F800000, 32'h7FC00002,
          32'hFFC00003, 32'h3E800000, 32'h40400000, 32'h3F000000};
    r = '{32'hFFC00000, 32'hFFC00000, 32'hFFC00000, 32'h7FC00001,
          32'hFFC00003, 32'h7F800000, 32'h002AAAAB, 32'h00000002};
    send(2'd2, a, b, '0, r, 6'b111011, "R7/R8");

    // Form 3 also full width; signed divide by zero (R4 R6)
    a = '{32'hBF800000, 32'h00800000, 32'h40C00000, 32'h3F800000,
          32'h3F800000, 32'h3F800000, 32'h80000000, 32'h3F800000};
    b = '{32'h00000000, 32'h40000000, 32'h40000000, 32'h3F800000,
          32'h3F800000, 32'h3F800000, 32'hC0000000, 32'h3F800000};
    r = '{32'hFF800000, 32'h00400000, 32'h40400000, 32'h3F800000,
          32'h3F800000, 32'h3F800000, 32'h00000000, 32'h3F800000};
    send(2'd3, a, b, '0, r, 6'b000100, "R4/R6");

    while (done_ops < 5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule